// File: doc/BRIEF.md
# Load String Word Register Sequencer

This block executes a load-string-word operation against a 32-entry, 64-bit general register file. On a start pulse it takes a first destination register, a base register index with its value, an optional index register with its value, and a byte count. The count comes either from a 5-bit immediate field or from a 7-bit count value. It forms the effective address, then fetches bytes one per handshake from a byte-wide memory port. The bytes are packed, most significant first, into the low 32 bits of successive destination registers, and each register is written through a single register-file write port.

Destination numbering wraps from 31 back to 0. The sequence ends early, without writing it, on the first register that is also the address base or, in the indexed form, the index register. When the core runs little-endian the block writes nothing and raises a fault. A busy flag covers the operation and a done pulse closes it.

Top module: `lsw_seq`

## Requirements
- R1: A count of n bytes writes ceil(n/4) registers, starting at `rt` and going upward. Each register gets its bytes in bits 31:0, with the first byte in bits 31:24, the next in 23:16, and so on.
- R2: Byte positions of a written register that receive no data are zero, bits 63:32 of every written register are zero, and registers past the last one written keep their old value.
- R3: In the immediate form (`indexed`=0) an `imm_cnt` of 0 means 32 bytes. The effective address is `ra_val`, or 0 when `ra` is 0.
- R4: In the indexed form (`indexed`=1) the count is `cnt_reg` and the effective address is (`ra_val`, or 0 when `ra` is 0) plus `rb_val`. A count of 0 writes nothing and pulses `done` in the cycle after start.
- R5: After register 31 the sequence continues at register 0.
- R6: When the sequence reaches register `ra` (only if `ra` is not 0), or register `rb` in the indexed form, that register is not written, no further bytes are read, and `done` pulses one cycle later.
- R7: With `le_mode`=1 at start the block reads no memory and writes no register, and `fault` and `done` pulse together in the cycle after start.
- R8: One byte is taken in each cycle with `mem_valid` and `mem_ready` both high. The first address is the effective address, and each later address is the previous one plus one.
- R9: `busy` is high from the cycle after an accepted start until the operation ends. `done` is a one-cycle pulse in the cycle after the final write. A start while busy is ignored.
- R10: After reset `busy`, `done`, `fault`, `mem_valid` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken when not busy |
| indexed | input | 1 | 1: indexed form, 0: immediate form |
| le_mode | input | 1 | Core runs little-endian; causes a fault |
| rt | input | 5 | First destination register |
| ra | input | 5 | Base register index (0 means no base) |
| rb | input | 5 | Index register index (indexed form) |
| imm_cnt | input | 5 | Immediate byte count, 0 means 32 |
| cnt_reg | input | CW | Byte count for the indexed form |
| ra_val | input | XLEN | Content of register `ra` |
| rb_val | input | XLEN | Content of register `rb` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | End-of-operation pulse |
| fault | output | 1 | Alignment fault pulse |
| mem_valid | output | 1 | Byte read request |
| mem_addr | output | AW | Byte address |
| mem_ready | input | 1 | Memory accepts the request; data valid |
| mem_data | input | 8 | Read byte, valid with `mem_ready` |
| wr_en | output | 1 | Register write enable |
| wr_idx | output | 5 | Register write index |
| wr_data | output | XLEN | Register write data |

## Verification
The end of the byte count and the stop on a protected register can both arise at the same register boundary. The count may run out exactly where the next register would be the base register. Directed cases place the base register right after the last destination and right after a partial one. Randomized cases give the memory random ready patterns and random base and index registers. Each run is judged against a bench model of the whole register file, and the bench also checks that exactly one `done` pulse follows and that the write count matches the model.

// File: rtl/lsw_seq.sv
module lsw_seq #(
  parameter int XLEN = 64,
  parameter int AW   = 32,
  parameter int CW   = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            indexed,
  input  logic            le_mode,
  input  logic [4:0]      rt,
  input  logic [4:0]      ra,
  input  logic [4:0]      rb,
  input  logic [4:0]      imm_cnt,
  input  logic [CW-1:0]   cnt_reg,
  input  logic [XLEN-1:0] ra_val,
  input  logic [XLEN-1:0] rb_val,
  output logic            busy,
  output logic            done,
  output logic            fault,
  output logic            mem_valid,
  output logic [AW-1:0]   mem_addr,
  input  logic            mem_ready,
  input  logic [7:0]      mem_data,
  output logic            wr_en,
  output logic [4:0]      wr_idx,
  output logic [XLEN-1:0] wr_data
);
  logic [4:0]      cur, ra_q, rb_q;
  logic            ra_chk, rb_chk;
  logic [CW-1:0]   rem, n_start;
  logic [1:0]      pos;
  logic [31:0]     acc, acc_nx;
  logic [XLEN-1:0] ea_full;
  logic            go, prot, stop, hs, last_byte;

  assign n_start   = indexed ? cnt_reg : (imm_cnt == 5'd0 ? CW'(32) : CW'(imm_cnt));
  assign ea_full   = (ra == 5'd0 ? '0 : ra_val) + (indexed ? rb_val : '0);
  assign go        = start && !busy;
  assign prot      = (ra_chk && cur == ra_q) || (rb_chk && cur == rb_q);
  assign stop      = busy && pos == 2'd0 && prot;
  assign mem_valid = busy && !stop;
  assign hs        = mem_valid && mem_ready;
  assign last_byte = rem == CW'(1);
  assign acc_nx    = acc | ({mem_data, 24'h0} >> {pos, 3'b000});
  assign wr_en     = hs && (pos == 2'd3 || last_byte);
  assign wr_idx    = cur;
  assign wr_data   = {{(XLEN-32){1'b0}}, acc_nx};
  assign mem_addr  = mem_addr_q;

  logic [AW-1:0] mem_addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; fault <= 1'b0;
      cur <= '0; ra_q <= '0; rb_q <= '0; ra_chk <= 1'b0; rb_chk <= 1'b0;
      rem <= '0; pos <= '0; acc <= '0; mem_addr_q <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      if (go) begin
        if (le_mode) begin
          done  <= 1'b1;
          fault <= 1'b1;
        end else if (n_start == '0) begin
          done <= 1'b1;
        end else begin
          busy       <= 1'b1;
          cur        <= rt;
          rem        <= n_start;
          pos        <= 2'd0;
          acc        <= '0;
          mem_addr_q <= AW'(ea_full);
          ra_q       <= ra;
          rb_q       <= rb;
          ra_chk     <= ra != 5'd0;
          rb_chk     <= indexed;
        end
      end else if (stop) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else if (hs) begin
        mem_addr_q <= mem_addr_q + AW'(1);
        rem        <= rem - CW'(1);
        pos        <= pos + 2'd1;
        acc        <= acc_nx;
        if (wr_en) begin
          acc <= '0;
          cur <= cur + 5'd1;
        end
        if (last_byte) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R6: a write never lands on a protected register
  a_r6_no_base_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !((ra_chk && wr_idx == ra_q) || (rb_chk && wr_idx == rb_q)));

  // R7: little-endian start gives fault and done at once, nothing else
  a_r7_le_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && le_mode) |=> (fault && done && !busy && !wr_en));

  // R4: indexed zero count ends immediately
  a_r4_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && indexed && !le_mode && cnt_reg == '0) |=> (done && !busy));

  // R8: address steps by one per accepted byte
  a_r8_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=> (!busy || mem_addr == $past(mem_addr) + AW'(1)));

  // R9: done is a single pulse, and the port is quiet when idle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_valid && !wr_en));

  // R7: a fault always comes with done
  a_r7_fault_done: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done);
endmodule

// File: tb/lsw_seq_bench.sv
module lsw_seq_bench;
  localparam int XLEN = 64, AW = 32, CW = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, indexed = 1'b0, le_mode = 1'b0;
  logic [4:0] rt = '0, ra = '0, rb = '0, imm_cnt = '0;
  logic [CW-1:0] cnt_reg = '0;
  logic [XLEN-1:0] ra_val = '0, rb_val = '0;
  logic busy, done, fault, mem_valid, mem_ready = 1'b0, wr_en;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_data;
  logic [4:0] wr_idx;
  logic [XLEN-1:0] wr_data;

  always #2 clk = ~clk;

  function automatic logic [7:0] bfn(input logic [AW-1:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3c;
  endfunction
  assign mem_data = bfn(mem_addr);

  lsw_seq #(.XLEN(XLEN), .AW(AW), .CW(CW)) u_lsw_seq (
    .clk, .rst_n, .start, .indexed, .le_mode, .rt, .ra, .rb, .imm_cnt, .cnt_reg,
    .ra_val, .rb_val, .busy, .done, .fault, .mem_valid, .mem_addr, .mem_ready,
    .mem_data, .wr_en, .wr_idx, .wr_data);

  int checks = 0, fails = 0;
  logic [63:0] rf [32];
  logic [63:0] exp_rf [32];
  int exp_writes;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic model(input bit idx, input bit le, input logic [4:0] t, input logic [4:0] a,
                       input logic [4:0] b, input int n, input logic [AW-1:0] ea);
    logic [AW-1:0] ad = ea;
    int r = t, left = n;
    for (int i = 0; i < 32; i++) exp_rf[i] = '1;
    exp_writes = 0;
    if (le) return;
    while (left > 0) begin
      logic [31:0] w = '0;
      if ((a != 0 && r == a) || (idx && r == b)) break;
      for (int k = 0; k < 4; k++)
        if (left > 0) begin
          w = w | (32'(bfn(ad)) << (24 - 8 * k));
          ad = ad + 1; left--;
        end
      exp_rf[r] = {32'h0, w};
      exp_writes++;
      r = (r + 1) % 32;
    end
  endtask

  task automatic run_op(input string req, input bit idx, input bit le, input logic [4:0] t,
                        input logic [4:0] a, input logic [4:0] b, input logic [4:0] imm,
                        input logic [CW-1:0] cnt, input logic [63:0] av, input logic [63:0] bv,
                        input bit disturb);
    int n, nwr = 0, ndone = 0, cyc = 0;
    bit fseen = 0, first = 1;
    logic [63:0] eaf;
    n   = idx ? int'(cnt) : (imm == 0 ? 32 : int'(imm));
    eaf = (a == 0 ? 64'h0 : av) + (idx ? bv : 64'h0);
    model(idx, le, t, a, b, n, AW'(eaf));
    for (int i = 0; i < 32; i++) rf[i] = '1;
    @(negedge clk);
    indexed = idx; le_mode = le; rt = t; ra = a; rb = b; imm_cnt = imm; cnt_reg = cnt;
    ra_val = av; rb_val = bv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    forever begin
      mem_ready = ($urandom % 4) != 0;
      if (disturb && cyc == 1) begin start = 1'b1; rt = t ^ 5'd7; imm_cnt = imm ^ 5'd3; end
      if (disturb && cyc == 2) start = 1'b0;
      #1;
      if (mem_valid && first) begin
        chk(mem_addr == AW'(eaf), {req, " R8 first address"}, 64'(mem_addr), 64'(AW'(eaf)));
        first = 0;
      end
      if (wr_en) begin rf[wr_idx] = wr_data; nwr++; end
      if (done) begin ndone++; fseen = fault; break; end
      cyc++;
      if (cyc > 600) begin
        chk(0, {req, " R9 watchdog"}, 64'(cyc), 64'd600);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk); #1;
    chk(!done && !busy, {req, " R9 done single pulse"}, {62'h0, done, busy}, 64'h0);
    chk(fseen == le, {req, " R7 fault"}, 64'(fseen), 64'(le));
    chk(nwr == exp_writes, {req, " R1 write count"}, 64'(nwr), 64'(exp_writes));
    for (int i = 0; i < 32; i++)
      chk(rf[i] === exp_rf[i], {req, $sformatf(" register %0d", i)}, rf[i], exp_rf[i]);
  endtask

  initial begin
    #(4 * 190000);
    chk(0, "R9 global watchdog", 0, 1);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !done && !fault && !mem_valid && !wr_en, "R10 reset state",
        {59'h0, busy, done, fault, mem_valid, wr_en}, 64'h0);
    rst_n = 1'b1;
    void'($urandom(32'd4242));
    run_op("R1 R2 partial 3 bytes", 0, 0, 5'd11, 5'd5, 5'd0, 5'd3, '0, 64'h100, 0, 0);
    run_op("R3 imm zero is 32 bytes", 0, 0, 5'd11, 5'd3, 5'd0, 5'd0, '0, 64'h2040, 0, 0);
    run_op("R3 ra zero base", 0, 0, 5'd20, 5'd0, 5'd0, 5'd6, '0, 64'hdead, 0, 0);
    run_op("R5 wrap 31 to 0", 0, 0, 5'd31, 5'd5, 5'd0, 5'd8, '0, 64'h300, 0, 0);
    run_op("R6 stop at base", 0, 0, 5'd31, 5'd1, 5'd0, 5'd10, '0, 64'h380, 0, 0);
    run_op("R6 stop at index", 1, 0, 5'd31, 5'd0, 5'd0, 5'd0, 7'd12, 0, 64'h480, 0);
    run_op("R6 count ends at base", 0, 0, 5'd3, 5'd5, 5'd0, 5'd8, '0, 64'h500, 0, 0);
    run_op("R6 partial ends at base", 1, 0, 5'd3, 5'd7, 5'd5, 5'd0, 7'd7, 64'h10, 64'h20, 0);
    run_op("R4 indexed sum", 1, 0, 5'd12, 5'd4, 5'd9, 5'd0, 7'd5, 64'h1000, 64'h77, 0);
    run_op("R4 indexed zero", 1, 0, 5'd12, 5'd4, 5'd9, 5'd0, 7'd0, 64'h1000, 64'h77, 0);
    run_op("R7 little endian", 0, 1, 5'd12, 5'd4, 5'd0, 5'd8, '0, 64'h1000, 0, 0);
    run_op("R9 start while busy", 0, 0, 5'd14, 5'd2, 5'd0, 5'd20, '0, 64'h1234, 0, 1);
    run_op("R4 long count", 1, 0, 5'd1, 5'd0, 5'd0, 5'd0, 7'd127, 0, 64'h9999, 0);
    for (int it = 0; it < 150; it++) begin
      logic [4:0] rnd_rt = 5'($urandom), rnd_ra = 5'($urandom), rnd_rb = 5'($urandom);
      logic [4:0] rnd_imm = 5'($urandom);
      logic [CW-1:0] rnd_cnt = CW'($urandom);
      bit rnd_idx = ($urandom % 2) == 1, rnd_le = ($urandom % 16) == 0;
      run_op("R1 R2 R5 R6 R8 random", rnd_idx, rnd_le, rnd_rt, rnd_ra, rnd_rb, rnd_imm, rnd_cnt,
             {32'h0, $urandom}, {48'h0, 16'($urandom)}, ($urandom % 8) == 0);
    end
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule